// File: doc/BRIEF.md
# Shared Bus Arbiter with Grant Parking

The block decides which of six master agents may drive a shared PCI-style bus. Each agent pulls its own active-low request line when it wants the bus, and the arbiter answers on a matching active-low grant line. The arbiter watches the bus FRAME_n and IRDY_n lines for two purposes. It learns from them when the bus is idle. It also learns which granted agent really started a transaction.

When nobody is asking for the bus, the grant is not withdrawn. It stays parked on the agent that most recently used the bus. The next access by that agent therefore costs no arbitration time. A fresh request on an idle bus is answered two clock edges after it is first sampled. Between two different owners there is always one cycle in which every grant is high. Competing requests are served round-robin, and the search starts just after the last agent that used the bus. Grants never move while a transaction is in flight.

Top module: `arbiter_park`

## Requirements
- R1: No more than one bit of `gnt_n` is low in any cycle.
- R2: While `rst` is high at a clock edge, every bit of `gnt_n` is high afterwards. At the first edge after `rst` falls with the bus idle, `gnt_n[0]` goes low: the arbiter parks on agent 0.
- R3: Take a request first sampled low at edge E on an idle bus, where the bus is parked on another agent. That agent's grant goes low after edge E+2. Once all grants are high and the bus is idle, a grant goes low at the next edge.
- R4: When the grant passes from one agent to a different agent, all bits of `gnt_n` are high for exactly one cycle in between.
- R5: If `frame_n` or `irdy_n` is low at an edge, `gnt_n` does not change at that edge.
- R6: The last active master is the granted agent seen with `frame_n` low at an edge. On an idle bus with no requests, the grant goes to the last active master and stays there.
- R7: Among simultaneous requests, the winner is the first requester found when searching upward from last active master + 1, wrapping from agent 5 to agent 0.
- R8: An agent that is granted but drops its request without driving `frame_n` low does not become the last active master. Two edges after the drop is sampled, the grant is taken from it, and it goes either to the round-robin winner or back to the last active master.
- R9: An agent may release its request in the same cycle it drives `frame_n` low. After its transaction ends, the grant stays parked on it.
- R10: A granted agent that is still requesting and has not yet started a transaction keeps its grant, even when other agents also request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_MASTERS | Per-agent bus request, active low |
| frame_n | input | 1 | Bus FRAME_n, low while a transaction runs |
| irdy_n | input | 1 | Bus IRDY_n, low while the initiator is in a data phase |
| gnt_n | output | NUM_MASTERS | Per-agent bus grant, active low |

## Verification
The hardest situation to reach is the round-robin choice after the wrap-around, combined with a grant that is withdrawn from an agent that never used the bus. Only that combination shows whether the last active master was updated wrongly. The stimulus first lets agent 5 run a transaction while agents 0 and 1 keep requesting through a long busy period. The next search must then wrap to agent 0. Later, agents 1 and 4 are granted in turn and both drop their requests without driving FRAME_n. The grant must then return to agent 0, and that return exposes any wrong update of the last-active record.

// File: rtl/arb_park_pkg.sv
package arb_park_pkg;

    localparam int DEFAULT_MASTERS = 6;

    // Grant phase: a blanking cycle before a new owner, or an owner holding the grant
    typedef enum logic {
        PH_BLANK = 1'b0,
        PH_HOLD  = 1'b1
    } grant_phase_e;

    // Bus is idle only when neither FRAME_n nor IRDY_n is driven low
    function automatic logic bus_idle(input logic frame_n, input logic irdy_n);
        return frame_n & irdy_n;
    endfunction

endpackage

// File: rtl/arb_req_sample.sv
module arb_req_sample #(
    parameter int NUM_MASTERS = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_n,
    output logic [NUM_MASTERS-1:0] req_q
);

    // One register stage turns the active-low pins into active-high requests
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= ~req_n;
        end
    end

endmodule

// File: rtl/arb_rr_select.sv
module arb_rr_select #(
    parameter int NUM_MASTERS = 6,
    parameter int IDX_W       = 3
) (
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]       last_idx,
    output logic                   found,
    output logic [IDX_W-1:0]       pick
);

    // Search begins at last_idx+1 and wraps, so the last user has the lowest rank
    always_comb begin
        int               cand;
        logic [IDX_W-1:0] cand_b;
        found = 1'b0;
        pick  = last_idx;
        for (int off = 1; off <= NUM_MASTERS; off++) begin
            cand = int'(last_idx) + off;
            if (cand >= NUM_MASTERS) begin
                cand = cand - NUM_MASTERS;
            end
            cand_b = IDX_W'(cand);
            if (!found && req[cand_b]) begin
                found = 1'b1;
                pick  = cand_b;
            end
        end
    end

endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import arb_park_pkg::*;
#(
    parameter int NUM_MASTERS = 6,
    parameter int IDX_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_q,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    input  logic                   rr_found,
    input  logic [IDX_W-1:0]       rr_pick,
    output logic [IDX_W-1:0]       last_idx,
    output logic [NUM_MASTERS-1:0] gnt_n
);

    typedef struct packed {
        grant_phase_e     phase;
        logic [IDX_W-1:0] owner;
    } grant_state_t;

    grant_state_t     cur;
    logic [IDX_W-1:0] target;
    logic             keep_owner;
    logic             idle;

    assign idle = bus_idle(frame_n, irdy_n);

    // A granted agent that has not yet used the bus keeps it while it still asks
    assign keep_owner = (cur.phase == PH_HOLD) && req_q[cur.owner] && (cur.owner != last_idx);

    always_comb begin
        if (keep_owner) begin
            target = cur.owner;
        end else if (rr_found) begin
            target = rr_pick;
        end else begin
            target = last_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.phase <= PH_BLANK;
            cur.owner <= '0;
            last_idx  <= '0;
        end else begin
            // FRAME_n low while holding the grant marks the owner as the last user
            if (cur.phase == PH_HOLD && !frame_n) begin
                last_idx <= cur.owner;
            end
            unique case (cur.phase)
                PH_HOLD: begin
                    if (idle && target != cur.owner) begin
                        cur.phase <= PH_BLANK;
                        cur.owner <= target;
                    end
                end
                PH_BLANK: begin
                    if (idle) begin
                        cur.phase <= PH_HOLD;
                    end
                end
                default: cur.phase <= PH_BLANK;
            endcase
        end
    end

    // Per-agent grant decode
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_gnt
        assign gnt_n[g] = !(cur.phase == PH_HOLD && cur.owner == IDX_W'(g));
    end

endmodule

// File: rtl/arbiter_park.sv
module arbiter_park
    import arb_park_pkg::*;
#(
    parameter int NUM_MASTERS = DEFAULT_MASTERS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_n,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    output logic [NUM_MASTERS-1:0] gnt_n
);

    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    logic [NUM_MASTERS-1:0] req_q;
    logic [IDX_W-1:0]       last_idx;
    logic                   rr_found;
    logic [IDX_W-1:0]       rr_pick;

    arb_req_sample #(
        .NUM_MASTERS(NUM_MASTERS)
    ) u_sample (
        .clk   (clk),
        .rst   (rst),
        .req_n (req_n),
        .req_q (req_q)
    );

    arb_rr_select #(
        .NUM_MASTERS(NUM_MASTERS),
        .IDX_W      (IDX_W)
    ) u_select (
        .req      (req_q),
        .last_idx (last_idx),
        .found    (rr_found),
        .pick     (rr_pick)
    );

    arb_grant_fsm #(
        .NUM_MASTERS(NUM_MASTERS),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_q    (req_q),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .rr_found (rr_found),
        .rr_pick  (rr_pick),
        .last_idx (last_idx),
        .gnt_n    (gnt_n)
    );

endmodule

// File: rtl/arbiter_park_checker.sv
module arbiter_park_checker #(
    parameter int NUM_MASTERS = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_MASTERS-1:0] req_n,
    input logic                   frame_n,
    input logic                   irdy_n,
    input logic [NUM_MASTERS-1:0] gnt_n
);

    localparam logic [NUM_MASTERS-1:0] NONE = '1;

    logic unused_req;
    assign unused_req = ^req_n;

    // R1: at most one grant low
    a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));

    // R4: a held grant either stays or goes fully high before another owner
    a_r4_blank_between_owners: assert property (@(posedge clk) disable iff (rst)
        (gnt_n != NONE) |=> (gnt_n == NONE || gnt_n == $past(gnt_n)));

    // R5: busy bus freezes the grant
    a_r5_no_preempt: assert property (@(posedge clk) disable iff (rst)
        (!frame_n || !irdy_n) |=> $stable(gnt_n));

    // R3: blanking on an idle bus lasts one cycle
    a_r3_blank_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (gnt_n == NONE && frame_n && irdy_n) |=> (gnt_n != NONE));

endmodule

bind arbiter_park arbiter_park_checker #(
    .NUM_MASTERS(NUM_MASTERS)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n)
);

// File: tb/test_arbiter_park.sv
module test_arbiter_park;

    localparam int N = 6;
    localparam logic [N-1:0] NONE = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_n = '1;
    logic         frame_n = 1'b1;
    logic         irdy_n = 1'b1;
    logic [N-1:0] gnt_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int           when;
        logic [N-1:0] val;
        string        tag;
    } item_t;

    item_t sb[$];

    arbiter_park #(.NUM_MASTERS(N)) i_arbiter_park (
        .clk     (clk),
        .rst     (rst),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .gnt_n   (gnt_n)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int d, input logic [N-1:0] v, input string tag);
        item_t it;
        it.when = cyc + d;
        it.val  = v;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop every item due this cycle and compare against gnt_n
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].when <= cyc) begin
                checks++;
                if (sb[i].when != cyc || gnt_n !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d gnt_n=%b expected %b (due %0d)",
                             sb[i].tag, cyc, gnt_n, sb[i].val, sb[i].when);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2: reset state, then park on agent 0
        tick(3);
        expect_at(1, NONE, "R2 reset");
        tick(1);
        rst = 1'b0;
        expect_at(1, 6'b111110, "R2 park agent0");
        tick(1);
        expect_at(1, 6'b111110, "R6 park on initial last");
        tick(2);

        // R3/R4/R1: single request from agent 3
        req_n[3] = 1'b0;
        expect_at(1, 6'b111110, "R3 no grant before latency");
        expect_at(2, NONE,      "R4 blank cycle");
        expect_at(3, 6'b110111, "R3 grant two edges after sampling");
        tick(3);
        // R9: request released in the same cycle FRAME_n asserts
        frame_n = 1'b0;
        irdy_n  = 1'b0;
        req_n   = '1;
        expect_at(1, 6'b110111, "R9 grant kept at frame");
        tick(1);
        frame_n = 1'b1;
        tick(1);
        irdy_n = 1'b1;
        expect_at(1, 6'b110111, "R9 parked after transaction");
        expect_at(3, 6'b110111, "R6 park on last active");
        tick(4);

        // R7: agents 5, 1, 0 request; last active is 3, so 5 wins
        req_n = 6'b011100;
        expect_at(2, NONE,      "R4 blank before agent5");
        expect_at(3, 6'b011111, "R7 round robin picks 5");
        tick(3);
        frame_n = 1'b0;
        irdy_n  = 1'b0;
        req_n   = 6'b111100;
        expect_at(1, 6'b011111, "R5 hold at frame");
        expect_at(2, 6'b011111, "R5 hold while busy");
        expect_at(3, 6'b011111, "R5 hold while busy");
        tick(1);
        frame_n = 1'b1;
        tick(2);
        irdy_n = 1'b1;
        expect_at(1, NONE,      "R4 blank before agent0");
        expect_at(2, 6'b111110, "R7 wrap to agent0");
        tick(2);
        frame_n = 1'b0;
        req_n   = 6'b111101;
        tick(1);
        frame_n = 1'b1;
        expect_at(1, NONE,      "R4 blank before agent1");
        expect_at(2, 6'b111101, "R7 next requester agent1");
        tick(2);

        // R10: agent 4 joins while agent 1 still requests without transacting
        req_n = 6'b101101;
        expect_at(1, 6'b111101, "R10 owner keeps grant");
        expect_at(2, 6'b111101, "R10 owner keeps grant");
        tick(2);
        // R8: agent 1 drops without FRAME_n
        req_n = 6'b101111;
        expect_at(1, 6'b111101, "R8 grant before withdrawal");
        expect_at(2, NONE,      "R8 blank after drop");
        expect_at(3, 6'b101111, "R8 grant to agent4");
        tick(3);
        req_n = '1;
        expect_at(1, 6'b101111, "R8 grant before withdrawal");
        expect_at(2, NONE,      "R8 blank after drop");
        expect_at(3, 6'b111110, "R8 return to unchanged last active 0");
        tick(6);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule